// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block drives a small set of pulse-width-modulated outputs. Each channel owns one 32-bit control word that sets a clock divider, an 8-bit duty value, a force-high flag and an enable. Software writes these words over a simple memory-mapped bus. The bus has one address and a write strobe, and reads are combinational.

For each channel, the source clock is divided by (divider + 1) to make a tick. An 8-bit period counter advances once per tick, so one output period spans 256 ticks. The output is high while the counter is below the duty value. When the force-high flag is set, the output is high for the whole period.

A write to a channel takes effect on the next clock edge and restarts that channel's period from tick zero. Clearing the enable drives the output low at once, even in the middle of a period.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every channel word reads as zero.
- R2: A channel word holds the divider in bits [12:0], the duty in bits [23:16], the force-high flag in bit 24 and the enable in bit 31. A read returns the last written value with bits [30:25] and [15:13] as zero.
- R3: Channel n decodes at byte address n*16. A write to an address whose low four bits are not zero is ignored, and so is a write to a channel index at or above the channel count. A read of such an address returns zero.
- R4: A divider value D gives one period-counter tick every D+1 clocks. For example, D=3 with duty 1 yields exactly 4 high clocks per 1024-clock period.
- R5: With the force-high flag clear, the output is high while the period counter is below the duty value. This gives duty*(D+1) high clocks, from the period start, out of every 256*(D+1) clocks.
- R6: A duty value of 0 with the force-high flag clear holds the output low.
- R7: With the force-high flag set, the output of an enabled channel stays high, whatever the duty field holds.
- R8: A channel whose enable bit is 0 drives its output low. Clearing the enable takes effect in the cycle after the write edge, in the middle of a period.
- R9: A write to a channel restarts its period at tick zero with the new settings. It does not finish the period in progress.
- R10: A write to one channel does not disturb the timing of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
The duty path is tried with duty values 0, 1, 128 and 255. It is run with dividers 0 and 3, and with the force-high flag set over both a zero and a full duty field. Counting high clocks over one whole period tells the tick rate apart from the compare threshold. Mid-period rewrites and disables show whether the old period is finished or dropped. Writes to the wrong offset, to a channel index past the end, and to a neighbouring channel show that decoding keeps the channels separate. A behavioural model runs beside the design and checks every output and the read data on each clock.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int DIV_W      = 13;
    localparam int DUTY_W     = 8;
    localparam int DUTY_LSB   = 16;
    localparam int FORCE_BIT  = 24;
    localparam int ENABLE_BIT = 31;
    localparam int STRIDE_LSB = 4;
    localparam int WORD_W     = 32;

    typedef struct packed {
        logic              enable;
        logic              force_hi;
        logic [DUTY_W-1:0] duty;
        logic [DIV_W-1:0]  divider;
    } chan_cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(chan_cfg_t c);
        logic [WORD_W-1:0] w;
        w                        = '0;
        w[DIV_W-1:0]             = c.divider;
        w[DUTY_LSB +: DUTY_W]    = c.duty;
        w[FORCE_BIT]             = c.force_hi;
        w[ENABLE_BIT]            = c.enable;
        return w;
    endfunction

    function automatic chan_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
        chan_cfg_t c;
        c.divider  = w[DIV_W-1:0];
        c.duty     = w[DUTY_LSB +: DUTY_W];
        c.force_hi = w[FORCE_BIT];
        c.enable   = w[ENABLE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [WORD_W-1:0]            bus_wdata,
    output logic [WORD_W-1:0]            bus_rdata,
    output chan_cfg_t [NUM_CH-1:0]       cfg_o,
    output logic [NUM_CH-1:0]            restart_o
);

    localparam int IDX_W = ADDR_W - STRIDE_LSB;

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
    } regs_state_t;

    regs_state_t          state_d, state_q;
    logic [IDX_W-1:0]     idx;
    logic                 aligned;
    logic [NUM_CH-1:0]    sel;

    always_comb begin
        idx       = bus_addr[ADDR_W-1:STRIDE_LSB];
        aligned   = (bus_addr[STRIDE_LSB-1:0] == '0);
        sel       = '0;
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            sel[i] = aligned && (idx == IDX_W'(i));
            if (sel[i]) begin
                bus_rdata = cfg_to_word(state_q.cfg[i]);
            end
        end
    end

    always_comb begin
        state_d   = state_q;
        restart_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_wr && sel[i]) begin
                state_d.cfg[i] = word_to_cfg(bus_wdata);
                restart_o[i]   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cfg_o = state_q.cfg;

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cfg_t         cfg_i,
    input  logic              restart_i,
    output logic [DUTY_W-1:0] period_cnt_o,
    output logic              pwm_o
);

    typedef struct packed {
        logic [DIV_W-1:0]  presc;
        logic [DUTY_W-1:0] period;
    } chan_state_t;

    chan_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (restart_i || !cfg_i.enable) begin
            state_d = '0;
        end else if (state_q.presc == cfg_i.divider) begin
            state_d.presc  = '0;
            state_d.period = state_q.period + DUTY_W'(1);
        end else begin
            state_d.presc  = state_q.presc + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign period_cnt_o = state_q.period;
    assign pwm_o        = cfg_i.enable && (cfg_i.force_hi || (state_q.period < cfg_i.duty));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0]               cfg;
    logic [NUM_CH-1:0]                    wr_hit;
    logic [NUM_CH-1:0]                    ch_en;
    logic [NUM_CH-1:0]                    ch_full;
    logic [NUM_CH-1:0][DUTY_W-1:0]        ch_duty;
    logic [NUM_CH-1:0][DUTY_W-1:0]        ch_cnt;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg),
        .restart_o (wr_hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_bank_chan u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_i        (cfg[g]),
            .restart_i    (wr_hit[g]),
            .period_cnt_o (ch_cnt[g]),
            .pwm_o        (pwm_out[g])
        );
        assign ch_en[g]   = cfg[g].enable;
        assign ch_full[g] = cfg[g].force_hi;
        assign ch_duty[g] = cfg[g].duty;
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       wr_hit,
    input logic [NUM_CH-1:0]       ch_en,
    input logic [NUM_CH-1:0]       ch_full,
    input logic [NUM_CH-1:0][7:0]  ch_duty,
    input logic [NUM_CH-1:0][7:0]  ch_cnt,
    input logic [NUM_CH-1:0]       pwm_out,
    input logic [31:0]             bus_rdata
);

    p_rdata_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 32'h7E00_E000) == 32'h0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_tick_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[g] && !wr_hit[g]) |=>
                ((ch_cnt[g] == $past(ch_cnt[g])) || (ch_cnt[g] == 8'($past(ch_cnt[g]) + 8'd1))));

        p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[g] && !ch_full[g] && (ch_duty[g] == 8'd0)) |-> !pwm_out[g]);

        p_full_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[g] && ch_full[g]) |-> pwm_out[g]);

        p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[g] |-> (!pwm_out[g] && (ch_cnt[g] == 8'd0)));

        p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit[g] |=> (ch_cnt[g] == 8'd0));
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .ch_en     (ch_en),
    .ch_full   (ch_full),
    .ch_duty   (ch_duty),
    .ch_cnt    (ch_cnt),
    .pwm_out   (pwm_out),
    .bus_rdata (bus_rdata)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCH = 4;
    localparam int AW  = 8;
    localparam logic [31:0] MASK = 32'h81FF_1FFF;
    localparam logic [31:0] EN   = 32'h8000_0000;
    localparam logic [31:0] FULL = 32'h0100_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    int m_cfg [NCH];
    int m_pre [NCH];
    int m_cnt [NCH];

    always #2.5 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic int addr_chan(logic [AW-1:0] a);
        if (a[3:0] != 4'h0) return -1;
        if (int'(a[AW-1:4]) >= NCH) return -1;
        return int'(a[AW-1:4]);
    endfunction

    // Behavioural reference: per-channel tick and period counters
    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_cfg[c] = 0; m_pre[c] = 0; m_cnt[c] = 0;
            end else if (bus_wr && addr_chan(bus_addr) == c) begin
                m_cfg[c] = int'(bus_wdata & MASK); m_pre[c] = 0; m_cnt[c] = 0;
            end else if (m_cfg[c][31] == 1'b0) begin
                m_pre[c] = 0; m_cnt[c] = 0;
            end else if (m_pre[c] == (m_cfg[c] & 32'h1FFF)) begin
                m_pre[c] = 0; m_cnt[c] = (m_cnt[c] + 1) % 256;
            end else begin
                m_pre[c] = m_pre[c] + 1;
            end
        end
    end

    function automatic logic model_out(int c);
        if (m_cfg[c][31] == 1'b0) return 1'b0;
        if (m_cfg[c][24]) return 1'b1;
        return m_cnt[c] < ((m_cfg[c] >> 16) & 255);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R5 output timing, R2 read data)
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            int c;
            logic [31:0] exp_rd;
            for (int k = 0; k < NCH; k++) chk("R5 per-cycle output", 32'(pwm_out[k]), 32'(model_out(k)));
            c = addr_chan(bus_addr);
            exp_rd = (c < 0) ? 32'h0 : 32'(m_cfg[c]);
            chk("R2 per-cycle read", bus_rdata, exp_rd);
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        chk(req, bus_rdata, exp);
    endtask

    task automatic measure(int ch, int n, output int highs, output int first_low);
        highs = 0; first_low = -1;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            #2;
            if (pwm_out[ch]) highs++;
            else if (first_low < 0) first_low = k;
        end
    endtask

    initial begin
        int h, fl;
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset outputs", 32'(pwm_out), 32'h0);
        chk("R1 reset read", bus_rdata, 32'h0);
        rst_n = 1'b1;
        rd_chk("R1 reset read ch3", 8'h30, 32'h0);

        // R2 field layout and unused bits
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 readback mask", 8'h00, 32'h81FF_1FFF);
        chk("R7 force high with full duty field", 32'(pwm_out[0]), 32'h1);

        // R7 force-high ignores duty 0
        wr(8'h00, EN | FULL);
        measure(0, 300, h, fl);
        chk("R7 force high duty0", 32'(h), 32'd300);

        // R6 duty zero
        wr(8'h00, EN);
        measure(0, 512, h, fl);
        chk("R6 duty zero low", 32'(h), 32'd0);

        // R5 half duty, divider 0
        wr(8'h00, EN | (32'd128 << 16));
        measure(0, 256, h, fl);
        chk("R5 duty128 highs", 32'(h), 32'd128);
        chk("R5 duty128 edge", 32'(fl), 32'd128);

        // R5 duty 255
        wr(8'h00, EN | (32'd255 << 16));
        measure(0, 256, h, fl);
        chk("R5 duty255 highs", 32'(h), 32'd255);

        // R4 divider 3, duty 1
        wr(8'h00, EN | (32'd1 << 16) | 32'd3);
        measure(0, 1024, h, fl);
        chk("R4 div3 highs", 32'(h), 32'd4);
        chk("R4 div3 edge", 32'(fl), 32'd4);

        // R9 rewrite mid-period restarts
        wr(8'h00, EN | (32'd100 << 16));
        repeat (150) @(negedge clk);
        #2;
        chk("R9 before rewrite low", 32'(pwm_out[0]), 32'h0);
        wr(8'h00, EN | (32'd250 << 16));
        measure(0, 256, h, fl);
        chk("R9 rewrite highs", 32'(h), 32'd250);
        chk("R9 rewrite edge", 32'(fl), 32'd250);

        // R8 disable mid-period
        wr(8'h00, EN | (32'd255 << 16));
        repeat (20) @(negedge clk);
        wr(8'h00, 32'd255 << 16);
        measure(0, 100, h, fl);
        chk("R8 disable immediate", 32'(fl), 32'd0);
        chk("R8 disabled highs", 32'(h), 32'd0);

        // R3 decode: stride, misaligned and out-of-range
        wr(8'h30, EN | FULL);
        #2;
        chk("R3 ch3 output", 32'(pwm_out[3]), 32'h1);
        rd_chk("R3 ch3 read", 8'h30, EN | FULL);
        wr(8'h14, EN | FULL);
        #2;
        chk("R3 misaligned ignored", 32'(pwm_out[1]), 32'h0);
        rd_chk("R3 ch1 untouched", 8'h10, 32'h0);
        rd_chk("R3 misaligned read", 8'h14, 32'h0);
        wr(8'h40, EN | FULL);
        rd_chk("R3 out-of-range read", 8'h40, 32'h0);
        rd_chk("R3 ch0 untouched", 8'h00, 32'(255) << 16);
        #0;
        chk("R3 outputs after bad writes", 32'(pwm_out), 32'h8);

        // R10 independence
        wr(8'h00, EN | (32'd128 << 16));
        repeat (50) @(negedge clk);
        wr(8'h20, EN | (32'd10 << 16));
        #2;
        chk("R10 ch0 high after ch2 write", 32'(pwm_out[0]), 32'h1);
        chk("R10 ch2 started", 32'(pwm_out[2]), 32'h1);
        repeat (80) @(negedge clk);
        #2;
        chk("R10 ch0 low at tick 132", 32'(pwm_out[0]), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule